// File: doc/BRIEF.md
# Split-Bank Unaligned Byte/Word Memory Port

This block sits between a 16-bit data path and a byte-addressed store built from two byte-wide banks. Bytes at even addresses live in the even bank and bytes at odd addresses live in the odd bank. Each bank has its own row address, so one request can reach two different rows in the same cycle.

A request carries a byte address, a size (byte or 16-bit word), a direction and write data. A word at an odd address needs only one access. The odd bank supplies the low byte from the current row. The even bank supplies the high byte from the following row. The two byte lanes are swapped on the way in and on the way out.

A byte write enables only the bank that holds the addressed byte. It never reads or rewrites the other byte of the word. Both banks are synchronous byte-wide memories written so that block RAM can be inferred.

Top module: `dual_bank_mem_if`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rd_valid` is 0.
- R2: `rd_valid` is 1 in exactly the cycle after a read request is accepted. A write request or an idle cycle gives `rd_valid` = 0 in the following cycle.
- R3: A word at an even address A stores `wdata[7:0]` at byte A and `wdata[15:8]` at byte A+1. A word read at A returns byte A in `rd_data[7:0]` and byte A+1 in `rd_data[15:8]`.
- R4: A word at an odd address A follows the same byte order as R3 and completes in a single request cycle. No extra cycles, no fault and no penalty are added for the misalignment.
- R5: A byte write at address A stores `wdata[7:0]` at byte A and leaves every other byte unchanged, including the other byte of the same 16-bit word. Address bit 0 selects the bank: 0 is the even bank, 1 is the odd bank.
- R6: A byte read at address A returns byte A in `rd_data[7:0]` and zero in `rd_data[15:8]`.
- R7: A word access at the highest odd address wraps. Its high byte is byte address 0.
- R8: A request can be accepted in every cycle. A read issued in the cycle right after a write to the same bytes returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | ROW_AW+1 | Byte address |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data, meaningful while rd_valid is 1 |

## Verification
Every read has its result due exactly one cycle after the request edge. `rd_valid` and `rd_data` both come from registers loaded at that edge. Writes take effect at the request edge itself, so a read in the next cycle must already see them. The bench drives each request on a falling edge. At the next falling edge it compares `rd_valid` with the kind of request that was just taken, and for reads it compares `rd_data` with the value a byte-array model computed when the request was issued. Byte-write isolation and address wrap are therefore observed through later reads at the port.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_BANK = 2;
  localparam int EVEN     = 0;
  localparam int ODD      = 1;

  typedef enum logic {
    LANE_STRAIGHT = 1'b0,
    LANE_SWAPPED  = 1'b1
  } lane_e;
endpackage

// File: rtl/dbm_addr_gen.sv
module dbm_addr_gen
  import dbm_pkg::*;
#(
  parameter int ROW_AW = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 valid,
  input  logic                                 write,
  input  logic                                 word,
  input  logic [ROW_AW:0]                      addr,
  input  logic [2*BYTE_W-1:0]                  wdata,
  output logic [NUM_BANK-1:0]                  bank_en,
  output logic                                 bank_we,
  output logic [NUM_BANK-1:0][ROW_AW-1:0]      bank_row,
  output logic [NUM_BANK-1:0][BYTE_W-1:0]      bank_wd,
  output lane_e                                lane,
  output logic                                 odd_sel
);
  logic [ROW_AW-1:0] row;
  logic [BYTE_W-1:0] lo_b, hi_b;

  assign row     = addr[ROW_AW:1];
  assign odd_sel = addr[0];
  assign lo_b    = wdata[BYTE_W-1:0];
  assign hi_b    = wdata[2*BYTE_W-1:BYTE_W];

  always_comb begin
    lane           = (word && odd_sel) ? LANE_SWAPPED : LANE_STRAIGHT;
    bank_we        = write;
    bank_en[EVEN]  = valid && (word || !odd_sel);
    bank_en[ODD]   = valid && (word || odd_sel);
    bank_row[ODD]  = row;
    bank_row[EVEN] = (lane == LANE_SWAPPED) ? row + 1'b1 : row;
    bank_wd[EVEN]  = (lane == LANE_SWAPPED) ? hi_b : lo_b;
    bank_wd[ODD]   = (word && !odd_sel) ? hi_b : lo_b;
  end

  // R5: a byte access drives exactly one bank
  a_r5_byte_single_bank: assert property (@(posedge clk) disable iff (rst)
    (valid && !word) |-> ($countones(bank_en) == 1));
  // R3: a word access drives both banks
  a_r3_word_two_banks: assert property (@(posedge clk) disable iff (rst)
    (valid && word) |-> (bank_en == 2'b11));
  // R4 / R7: unaligned word steps the even-bank row by one, modulo bank depth
  a_r4_unaligned_row_step: assert property (@(posedge clk) disable iff (rst)
    (valid && word && addr[0]) |-> (bank_row[EVEN] == ROW_AW'(bank_row[ODD] + 1'b1)));
  // R2: idle cycles touch no bank
  a_r2_idle_no_bank: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (bank_en == '0));
endmodule

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

  // R5: a bank that is not addressed, or is being written, keeps its read register
  a_r5_idle_bank_holds: assert property (@(posedge clk) disable iff (rst)
    (!en || we) |=> $stable(rdata));
endmodule

// File: rtl/dbm_read_merge.sv
module dbm_read_merge
  import dbm_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            issue_rd,
  input  lane_e                           lane,
  input  logic                            odd_sel,
  input  logic                            word,
  input  logic [NUM_BANK-1:0][BYTE_W-1:0] bank_q,
  output logic                            rd_valid,
  output logic [2*BYTE_W-1:0]             rd_data
);
  lane_e lane_q;
  logic  odd_q, word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      lane_q   <= LANE_STRAIGHT;
      odd_q    <= 1'b0;
      word_q   <= 1'b0;
    end else begin
      rd_valid <= issue_rd;
      if (issue_rd) begin
        lane_q <= lane;
        odd_q  <= odd_sel;
        word_q <= word;
      end
    end
  end

  always_comb begin
    if (word_q) begin
      rd_data = (lane_q == LANE_SWAPPED) ? {bank_q[EVEN], bank_q[ODD]}
                                         : {bank_q[ODD],  bank_q[EVEN]};
    end else begin
      rd_data = {{BYTE_W{1'b0}}, (odd_q ? bank_q[ODD] : bank_q[EVEN])};
    end
  end

  // R6: byte reads return zero in the upper lane
  a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !word_q) |-> (rd_data[2*BYTE_W-1:BYTE_W] == '0));
endmodule

// File: rtl/dual_bank_mem_if.sv
module dual_bank_mem_if
  import dbm_pkg::*;
#(
  parameter int ROW_AW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ROW_AW:0]     req_addr,
  input  logic [15:0]         req_wdata,
  output logic                rd_valid,
  output logic [15:0]         rd_data
);
  logic [NUM_BANK-1:0]             bank_en;
  logic                            bank_we;
  logic [NUM_BANK-1:0][ROW_AW-1:0] bank_row;
  logic [NUM_BANK-1:0][BYTE_W-1:0] bank_wd;
  logic [NUM_BANK-1:0][BYTE_W-1:0] bank_q;
  lane_e                           lane;
  logic                            odd_sel;
  logic                            issue_rd;

  assign issue_rd = req_valid && !req_write;

  dbm_addr_gen #(.ROW_AW(ROW_AW)) u_addr (
    .clk(clk), .rst(rst),
    .valid(req_valid), .write(req_write), .word(req_word),
    .addr(req_addr), .wdata(req_wdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_row(bank_row),
    .bank_wd(bank_wd), .lane(lane), .odd_sel(odd_sel)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    dbm_bank #(.AW(ROW_AW), .DW(BYTE_W)) u_bank (
      .clk(clk), .rst(rst),
      .en(bank_en[b]), .we(bank_we),
      .addr(bank_row[b]), .wdata(bank_wd[b]),
      .rdata(bank_q[b])
    );
  end

  dbm_read_merge u_merge (
    .clk(clk), .rst(rst),
    .issue_rd(issue_rd), .lane(lane), .odd_sel(odd_sel), .word(req_word),
    .bank_q(bank_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R2: read data strobe follows an accepted read by one cycle
  a_r2_read_then_valid: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);
  // R2: no strobe after a write or idle cycle
  a_r2_write_no_valid: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);
endmodule

// File: tb/dual_bank_mem_if_bench.sv
module dual_bank_mem_if_bench;
  localparam int ROW_AW = 8;
  localparam int NBYTES = 1 << (ROW_AW + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [ROW_AW:0]   req_addr = '0;
  logic [15:0]       req_wdata = '0;
  logic              rd_valid;
  logic [15:0]       rd_data;

  logic [7:0] ref_mem [NBYTES];
  int    vectors = 0, miscompares = 0;
  logic  exp_valid = 1'b0;
  logic [15:0] exp_data = '0;
  string exp_tag = "R2";

  always #4 clk = ~clk;   // 125 MHz

  dual_bank_mem_if #(.ROW_AW(ROW_AW)) u_dual_bank_mem_if (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check_prev(input string vtag);
    vectors++;
    if (rd_valid !== exp_valid) begin
      miscompares++;
      $display("FAIL %s rd_valid actual=%b expected=%b", vtag, rd_valid, exp_valid);
    end
    if (exp_valid) begin
      vectors++;
      if (rd_data !== exp_data) begin
        miscompares++;
        $display("FAIL %s rd_data actual=%h expected=%h", exp_tag, rd_data, exp_data);
      end
    end
  endtask

  // one request per call: drive at falling edge, checking the previous one first
  task automatic step(input logic v, input logic w, input logic wd,
                      input int a, input logic [15:0] d, input string tag);
    int a1;
    @(negedge clk);
    check_prev("R2");
    a1 = (a + 1) % NBYTES;
    req_valid = v; req_write = w; req_word = wd;
    req_addr = (ROW_AW+1)'(a); req_wdata = d;
    exp_valid = v && !w;
    exp_tag = tag;
    if (v && w) begin
      ref_mem[a] = d[7:0];
      if (wd) ref_mem[a1] = d[15:8];
    end else if (v) begin
      exp_data = wd ? {ref_mem[a1], ref_mem[a]} : {8'h00, ref_mem[a]};
    end
  endtask

  function automatic string read_tag(input logic wd, input int a);
    if (!wd) return "R6";
    if (a == NBYTES-1) return "R7";
    return (a % 2 == 1) ? "R4" : "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (rd_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 rd_valid in reset actual=%b expected=0", rd_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    check_prev("R1");

    // fill memory with aligned word writes (R3)
    for (int i = 0; i < NBYTES; i += 2)
      step(1, 1, 1, i, 16'((i * 37 + 5) ^ (i << 7)), "R3");
    step(0, 0, 0, 0, 16'h0, "R2");

    // aligned word read/write
    step(1, 1, 1, 10, 16'hBEEF, "R3");
    step(1, 0, 1, 10, 16'h0, "R3");
    // unaligned word write then back-to-back reads
    step(1, 1, 1, 21, 16'hA55A, "R4");
    step(1, 0, 1, 21, 16'h0, "R8");
    step(1, 0, 1, 20, 16'h0, "R4");
    step(1, 0, 1, 22, 16'h0, "R4");
    // byte writes leave neighbour bytes alone
    step(1, 1, 0, 40, 16'hFF11, "R5");
    step(1, 0, 1, 40, 16'h0, "R5");
    step(1, 1, 0, 43, 16'hFF22, "R5");
    step(1, 0, 1, 42, 16'h0, "R5");
    step(1, 0, 1, 43, 16'h0, "R5");
    step(1, 0, 0, 43, 16'h0, "R6");
    step(1, 0, 0, 42, 16'h0, "R6");
    // wrap at the top address
    step(1, 1, 1, NBYTES-1, 16'h7E81, "R7");
    step(1, 0, 1, NBYTES-1, 16'h0, "R7");
    step(1, 0, 0, 0, 16'h0, "R7");
    step(1, 0, 1, 0, 16'h0, "R7");
    // write after read, idle gaps
    step(0, 0, 0, 0, 16'h0, "R2");
    step(1, 1, 0, 7, 16'h0033, "R5");
    step(1, 0, 0, 7, 16'h0, "R8");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic v, w, wd;
      int a;
      v  = ($urandom % 8) != 0;
      w  = $urandom % 2;
      wd = $urandom % 2;
      a  = $urandom % NBYTES;
      step(v, w, wd, a, 16'($urandom), read_tag(wd, a));
    end
    step(0, 0, 0, 0, 16'h0, "R2");
    @(negedge clk);
    check_prev("R2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule